// File: doc/BRIEF.md
# Centre-aligned dual-slope PWM timer

This block is an up/down timer with two compare channels that produce symmetric, centre-aligned pulse-width waveforms. On every enabled tick the counter moves one step, climbing from zero to a ceiling value and then falling back to zero. Because the counter turns around at both ends, a pulse edge placed by a compare value on the rising slope has a mirror edge on the falling slope. The pulses therefore stay centred on the counter's zero point whatever their width. This suits motor drives and other loads that need the switching edges of several outputs spread apart.

The ceiling is either the all-ones count or the active compare value of channel A, chosen by one select input. Compare values are written into holding registers and only reach the compare logic at the turnaround point at the top. A new duty cycle therefore never takes effect halfway through a period. Each channel has a two-bit output mode: hold, toggle (channel A only, and only while the ceiling comes from channel A), non-inverting, or inverting. Sticky flags mark the return to zero and each compare match. The host clears each flag by pulsing its clear input. The tick is expected from an external prescaler.

Top module: `dspwm_timer`

## Requirements
- R1: The counter changes only on cycles where `tick` is high. It goes 0,1,…,TOP,TOP-1,…,1,0,1,… so each value, TOP included, lasts exactly one tick. A TOP of zero holds the counter at zero. A count above TOP while climbing turns the counter downward.
- R2: With `top_sel` = 0, TOP is 2^CNT_W−1 (255 by default). With `top_sel` = 1, TOP is channel A's active compare value.
- R3: Mode code 2 (non-inverting): on a tick where the count equals the channel's active compare value, the output is driven to 0 if the counter is climbing and to 1 if it is falling. The tick at TOP counts as climbing. The tick at zero counts as falling, except the first tick after reset. The output changes at the clock edge that samples that tick.
- R4: Mode code 3 (inverting): under the same conditions as R3, the output is driven to 1 while climbing and to 0 while falling.
- R5: Mode code 1 on channel A inverts `wave_a` on each compare match, but only while `top_sel` = 1. While `top_sel` = 0, mode code 1 leaves `wave_a` unchanged.
- R6: Mode code 0 on either channel, and mode code 1 on channel B, leave the output at its last value.
- R7: `ovf_flag` is set at the edge where the counter moves from a nonzero value to zero. It stays set until a cycle with `ovf_clr` high. A set event in the same cycle as a clear wins.
- R8: A compare write lands in a holding register. The active compare values take the held values at the edge of a tick where the counter is at or above TOP while climbing. Until then, outputs and flags follow the previous active value.
- R9: `cmpa_flag` / `cmpb_flag` are set by a tick whose count equals that channel's active compare value. Each flag stays set until its clear input is pulsed. A set event in the same cycle as a clear wins.
- R10: After reset the counter is zero and climbing, and both outputs, all flags and both compare values are zero.
- R11: With the tick high every cycle, the counter returns to zero every 2·TOP clock cycles (510 for TOP = 255). With non-inverting mode and compare value c strictly between 0 and TOP, the output is high for 2·c cycles of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable from the prescaler |
| top_sel | input | 1 | 0: ceiling is all ones; 1: ceiling is channel A's compare value |
| cmpa_wr | input | 1 | Write strobe for channel A's holding register |
| cmpa_din | input | CNT_W | Compare value for channel A |
| cmpb_wr | input | 1 | Write strobe for channel B's holding register |
| cmpb_din | input | CNT_W | Compare value for channel B |
| coma | input | 2 | Output mode of channel A (0 hold, 1 toggle, 2 non-inverting, 3 inverting) |
| comb | input | 2 | Output mode of channel B (0 and 1 hold, 2 non-inverting, 3 inverting) |
| ovf_clr | input | 1 | Clears the zero-reached flag |
| cmpa_clr | input | 1 | Clears channel A's match flag |
| cmpb_clr | input | 1 | Clears channel B's match flag |
| count | output | CNT_W | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Counter reached zero |
| cmpa_flag | output | 1 | Channel A compare match seen |
| cmpb_flag | output | 1 | Channel B compare match seen |

## Verification
Channel B's compare value is swept across the full 8-bit range in steps of 15, alternating the non-inverting and inverting modes. The high time measured over one 510-tick period is compared with 2·c, its complement, and the all-high or all-low results at 0 and 255. This separates a swapped slope direction or a wrong end-point rule from a correct one. The ceiling is moved through several channel-A values to check the 2·TOP period. A tick that is high only every third cycle shows that nothing moves between ticks. A write made in the middle of a period checks that the old compare value governs until the top turnaround. A per-cycle reference model tracks count, outputs and flags throughout, and further runs confirm that toggle mode depends on the ceiling select and that the hold modes stay frozen.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

   // Output mode codes of one compare channel
   typedef enum logic [1:0] {
      COM_HOLD    = 2'd0,
      COM_TOGGLE  = 2'd1,
      COM_CLR_UP  = 2'd2,
      COM_SET_UP  = 2'd3
   } com_mode_e;

   // Channel that may use toggle mode
   localparam int TOGGLE_CH = 0;

endpackage

// File: rtl/dspwm_slope_counter.sv
module dspwm_slope_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] top,
   output logic [W-1:0] cnt,
   output logic         dir_dn,
   output logic         load_stb,
   output logic         bottom_stb
);

   logic [W-1:0] cnt_nxt;
   logic         dn_nxt;
   logic         at_top;

   assign at_top = !dir_dn && (cnt >= top);

   always_comb begin
      cnt_nxt = cnt;
      dn_nxt  = dir_dn;
      if (!dir_dn) begin
         if (at_top) begin
            if (cnt != '0) begin
               cnt_nxt = cnt - 1'b1;
               dn_nxt  = 1'b1;
            end
         end else begin
            cnt_nxt = cnt + 1'b1;
         end
      end else begin
         if (cnt == '0) begin
            dn_nxt = 1'b0;
            if (top != '0) cnt_nxt = cnt + 1'b1;
         end else begin
            cnt_nxt = cnt - 1'b1;
         end
      end
   end

   assign load_stb   = tick && at_top;
   assign bottom_stb = tick && (cnt_nxt == '0) && (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dir_dn <= 1'b0;
      end else if (tick) begin
         cnt    <= cnt_nxt;
         dir_dn <= dn_nxt;
      end
   end

endmodule

// File: rtl/dspwm_cmp_reg.sv
module dspwm_cmp_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] din,
   input  logic         load,
   output logic [W-1:0] act
);

   logic [W-1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         act    <= '0;
      end else begin
         if (wr)   hold_q <= din;
         if (load) act    <= hold_q;
      end
   end

endmodule

// File: rtl/dspwm_channel.sv
module dspwm_channel
   import dspwm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] cnt,
   input  logic         dir_dn,
   input  logic [W-1:0] act,
   input  com_mode_e    mode,
   input  logic         tog_en,
   input  logic         flag_clr,
   output logic         wave,
   output logic         flag
);

   logic hit;
   logic wave_nxt;

   assign hit = tick && (cnt == act);

   always_comb begin
      wave_nxt = wave;
      if (hit) begin
         unique case (mode)
            COM_CLR_UP: wave_nxt = dir_dn;
            COM_SET_UP: wave_nxt = !dir_dn;
            COM_TOGGLE: if (tog_en) wave_nxt = !wave;
            default:    wave_nxt = wave;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave <= 1'b0;
         flag <= 1'b0;
      end else begin
         wave <= wave_nxt;
         flag <= hit || (flag && !flag_clr);
      end
   end

endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
   import dspwm_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             top_sel,
   input  logic             cmpa_wr,
   input  logic [CNT_W-1:0] cmpa_din,
   input  logic             cmpb_wr,
   input  logic [CNT_W-1:0] cmpb_din,
   input  logic [1:0]       coma,
   input  logic [1:0]       comb,
   input  logic             ovf_clr,
   input  logic             cmpa_clr,
   input  logic             cmpb_clr,
   output logic [CNT_W-1:0] count,
   output logic             wave_a,
   output logic             wave_b,
   output logic             ovf_flag,
   output logic             cmpa_flag,
   output logic             cmpb_flag
);

   localparam int             NCH  = 2;
   localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

   initial begin
      if (CNT_W < 2 || CNT_W > 16)
         $fatal(1, "dspwm_timer: CNT_W must lie in 2..16");
   end

   logic [CNT_W-1:0]          top_val;
   logic                      dir_dn;
   logic                      load_stb;
   logic                      bottom_stb;
   logic [NCH-1:0]            wr_v;
   logic [NCH-1:0][CNT_W-1:0] din_v;
   logic [NCH-1:0][CNT_W-1:0] act_v;
   logic [NCH-1:0][1:0]       mode_v;
   logic [NCH-1:0]            clr_v;
   logic [NCH-1:0]            tog_v;
   logic [NCH-1:0]            wave_v;
   logic [NCH-1:0]            flag_v;

   assign wr_v   = {cmpb_wr, cmpa_wr};
   assign din_v  = {cmpb_din, cmpa_din};
   assign mode_v = {comb, coma};
   assign clr_v  = {cmpb_clr, cmpa_clr};

   assign top_val = top_sel ? act_v[0] : FULL;

   dspwm_slope_counter #(.W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .top        (top_val),
      .cnt        (count),
      .dir_dn     (dir_dn),
      .load_stb   (load_stb),
      .bottom_stb (bottom_stb)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i == TOGGLE_CH) begin : g_tog
         assign tog_v[i] = top_sel;
      end else begin : g_notog
         assign tog_v[i] = 1'b0;
      end

      dspwm_cmp_reg #(.W(CNT_W)) u_cmp (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (wr_v[i]),
         .din   (din_v[i]),
         .load  (load_stb),
         .act   (act_v[i])
      );

      dspwm_channel #(.W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .tick     (tick),
         .cnt      (count),
         .dir_dn   (dir_dn),
         .act      (act_v[i]),
         .mode     (com_mode_e'(mode_v[i])),
         .tog_en   (tog_v[i]),
         .flag_clr (clr_v[i]),
         .wave     (wave_v[i]),
         .flag     (flag_v[i])
      );
   end

   assign wave_a    = wave_v[0];
   assign wave_b    = wave_v[1];
   assign cmpa_flag = flag_v[0];
   assign cmpb_flag = flag_v[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ovf_flag <= 1'b0;
      else if (bottom_stb) ovf_flag <= 1'b1;
      else if (ovf_clr)    ovf_flag <= 1'b0;
   end

endmodule

// File: rtl/dspwm_checker.sv
module dspwm_checker #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         top_sel,
   input logic [1:0]   coma,
   input logic [1:0]   comb,
   input logic [W-1:0] cnt,
   input logic         dir_dn,
   input logic [W-1:0] act_a,
   input logic [W-1:0] act_b,
   input logic         wave_a,
   input logic         wave_b,
   input logic         ovf_flag,
   input logic         cmpb_flag
);

   localparam logic [W-1:0] FULL = {W{1'b1}};

   p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   p_bottom_turn_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !top_sel && cnt == '0) |=> (cnt == W'(1)));

   p_full_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !top_sel && cnt == FULL) |=> (cnt == FULL - 1'b1));

   p_noninv_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && coma == 2'd2 && cnt == act_a && !dir_dn) |=> !wave_a);

   p_noninv_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && coma == 2'd2 && cnt == act_a && dir_dn) |=> wave_a);

   p_inv_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && comb == 2'd3 && cnt == act_b && !dir_dn) |=> wave_b);

   p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && coma == 2'd1 && top_sel && cnt == act_a) |=> (wave_a != $past(wave_a)));

   p_b_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (comb == 2'd0 || comb == 2'd1) |=> $stable(wave_b));

   p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && $past(cnt) != '0) |-> ovf_flag);

   p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && !dir_dn && (top_sel ? (cnt >= act_a) : (cnt == FULL)))
      |=> ($stable(act_a) && $stable(act_b)));

   p_flag_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == act_b) |=> cmpb_flag);

endmodule

bind dspwm_timer dspwm_checker #(.W(CNT_W)) u_dspwm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .top_sel   (top_sel),
   .coma      (coma),
   .comb      (comb),
   .cnt       (count),
   .dir_dn    (dir_dn),
   .act_a     (act_v[0]),
   .act_b     (act_v[1]),
   .wave_a    (wave_a),
   .wave_b    (wave_b),
   .ovf_flag  (ovf_flag),
   .cmpb_flag (cmpb_flag)
);

// File: tb/test_dspwm_timer.sv
`timescale 1ns/1ps
module test_dspwm_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       top_sel = 1'b0;
   logic       cmpa_wr = 1'b0;
   logic [7:0] cmpa_din = '0;
   logic       cmpb_wr = 1'b0;
   logic [7:0] cmpb_din = '0;
   logic [1:0] coma = '0;
   logic [1:0] comb = '0;
   logic       ovf_clr = 1'b0;
   logic       cmpa_clr = 1'b0;
   logic       cmpb_clr = 1'b0;
   logic [7:0] count;
   logic       wave_a, wave_b, ovf_flag, cmpa_flag, cmpb_flag;

   int checks = 0;
   int errors = 0;

   // reference state, from the requirements
   int m_cnt, m_dn, m_acta, m_actb, m_bufa, m_bufb, m_wa, m_wb, m_ovf, m_fa, m_fb;

   always #2 clk = ~clk;

   dspwm_timer #(.CNT_W(8)) i_dspwm_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .top_sel(top_sel),
      .cmpa_wr(cmpa_wr), .cmpa_din(cmpa_din), .cmpb_wr(cmpb_wr), .cmpb_din(cmpb_din),
      .coma(coma), .comb(comb), .ovf_clr(ovf_clr), .cmpa_clr(cmpa_clr), .cmpb_clr(cmpb_clr),
      .count(count), .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
      .cmpa_flag(cmpa_flag), .cmpb_flag(cmpb_flag)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int wave_next(int w, int com, int hit, int dn, int tog_ok);
      if (!hit) return w;
      case (com)
         2: return dn;
         3: return dn ? 0 : 1;
         1: return tog_ok ? 1 - w : w;
         default: return w;
      endcase
   endfunction

   // one clock: inputs are set at the falling edge, compared at the next one
   task automatic step(input logic tk);
      int top, ld, nc, nd, nwa, nwb, nacta, nactb, nbufa, nbufb, novf, nfa, nfb;
      tick  = tk;
      top   = top_sel ? m_acta : 255;
      nc = m_cnt; nd = m_dn; nwa = m_wa; nwb = m_wb; nacta = m_acta; nactb = m_actb;
      nbufa = cmpa_wr ? int'(cmpa_din) : m_bufa;
      nbufb = cmpb_wr ? int'(cmpb_din) : m_bufb;
      novf  = ovf_clr  ? 0 : m_ovf;
      nfa   = cmpa_clr ? 0 : m_fa;
      nfb   = cmpb_clr ? 0 : m_fb;
      if (tk) begin
         nwa = wave_next(m_wa, int'(coma), int'(m_cnt == m_acta), m_dn, int'(top_sel));
         nwb = wave_next(m_wb, int'(comb), int'(m_cnt == m_actb), m_dn, 0);
         if (m_cnt == m_acta) nfa = 1;
         if (m_cnt == m_actb) nfb = 1;
         ld = int'(m_dn == 0 && m_cnt >= top);
         if (m_dn == 0) begin
            if (ld != 0) begin
               if (m_cnt != 0) begin nc = m_cnt - 1; nd = 1; end
            end else nc = m_cnt + 1;
         end else begin
            if (m_cnt == 0) begin nd = 0; if (top != 0) nc = 1; end
            else nc = m_cnt - 1;
         end
         if (ld != 0) begin nacta = m_bufa; nactb = m_bufb; end
         if (nc == 0 && m_cnt != 0) novf = 1;
      end
      @(posedge clk);
      @(negedge clk);
      m_cnt = nc; m_dn = nd; m_wa = nwa; m_wb = nwb; m_acta = nacta; m_actb = nactb;
      m_bufa = nbufa; m_bufb = nbufb; m_ovf = novf; m_fa = nfa; m_fb = nfb;
      tick = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0;
      ovf_clr = 1'b0; cmpa_clr = 1'b0; cmpb_clr = 1'b0;
      chk(int'(count) == m_cnt, "R1", "count", int'(count), m_cnt);
      chk(int'(wave_a) == m_wa, "R3", "wave_a", int'(wave_a), m_wa);
      chk(int'(wave_b) == m_wb, "R4", "wave_b", int'(wave_b), m_wb);
      chk(int'(ovf_flag) == m_ovf, "R7", "ovf_flag", int'(ovf_flag), m_ovf);
      chk(int'(cmpa_flag) == m_fa, "R9", "cmpa_flag", int'(cmpa_flag), m_fa);
      chk(int'(cmpb_flag) == m_fb, "R9", "cmpb_flag", int'(cmpb_flag), m_fb);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step(1'b1);
   endtask

   task automatic wait_at(input int c, input int dn);
      while (!(m_cnt == c && m_dn == dn)) step(1'b1);
   endtask

   // cycles between two consecutive visits of zero, tick every cycle
   task automatic period_check(input int exp, input string req);
      int n = 0;
      while (count != 8'd0) step(1'b1);
      step(1'b1);
      n = 1;
      while (count != 8'd0) begin step(1'b1); n++; end
      chk(n == exp, req, "period", n, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hi, ex, tg, tgb, prev_a, prev_b, mx;
      m_cnt = 0; m_dn = 0; m_acta = 0; m_actb = 0; m_bufa = 0; m_bufb = 0;
      m_wa = 0; m_wb = 0; m_ovf = 0; m_fa = 0; m_fb = 0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(count == 8'd0, "R10", "count", int'(count), 0);
      chk({wave_a, wave_b} == 2'b00, "R10", "waves", int'({wave_a, wave_b}), 0);
      chk({ovf_flag, cmpa_flag, cmpb_flag} == 3'b000, "R10", "flags",
          int'({ovf_flag, cmpa_flag, cmpb_flag}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // free running, full-range ceiling
      top_sel = 1'b0; coma = 2'd2; comb = 2'd3;
      cmpa_din = 8'd64; cmpa_wr = 1'b1; cmpb_din = 8'd200; cmpb_wr = 1'b1;
      step(1'b1);
      run(1200);
      period_check(510, "R11");

      // R1: sparse tick, counter frozen between ticks (model compares every cycle)
      for (int i = 0; i < 300; i++) step((i % 3) == 0);

      // R3 / R4: duty sweep on channel B
      for (int k = 0; k < 18; k++) begin
         int c = k * 15;
         comb = (k % 2 == 1) ? 2'd3 : 2'd2;
         cmpb_din = 8'(c); cmpb_wr = 1'b1;
         step(1'b1);
         run(1020);
         hi = 0;
         for (int i = 0; i < 510; i++) begin step(1'b1); hi += int'(wave_b); end
         ex = (c == 0) ? 510 : (c == 255) ? 0 : 2 * c;
         if (k % 2 == 1) begin
            ex = 510 - ex;
            chk(hi == ex, "R4", "inverting high time", hi, ex);
         end else begin
            chk(hi == ex, "R3", "non-inverting high time", hi, ex);
         end
         if (c > 0 && c < 255 && k % 2 == 0)
            chk(hi == 2 * c, "R11", "duty 2c", hi, 2 * c);
      end

      // R8: write in mid-period waits for the top turnaround
      comb = 2'd2; cmpb_din = 8'd100; cmpb_wr = 1'b1;
      step(1'b1);
      run(1020);
      wait_at(50, 0);
      cmpb_din = 8'd20; cmpb_wr = 1'b1;
      step(1'b1);
      wait_at(101, 0);
      chk(wave_b == 1'b0, "R8", "old value cleared at 100", int'(wave_b), 0);
      wait_at(60, 1);
      chk(wave_b == 1'b0, "R8", "new value not yet set", int'(wave_b), 0);
      wait_at(10, 1);
      chk(wave_b == 1'b1, "R8", "new value set at 20", int'(wave_b), 1);

      // R2: ceiling from channel A
      top_sel = 1'b1; comb = 2'd2;
      for (int k = 0; k < 3; k++) begin
         int t = (k == 0) ? 10 : (k == 1) ? 37 : 100;
         cmpa_din = 8'(t); cmpa_wr = 1'b1;
         step(1'b1);
         run(600);
         period_check(2 * t, "R2");
         mx = 0;
         for (int i = 0; i < 2 * t; i++) begin step(1'b1); if (int'(count) > mx) mx = int'(count); end
         chk(mx == t, "R2", "peak count", mx, t);
      end

      // R5 / R6: toggle allowed only with ceiling from A; B never toggles
      coma = 2'd1; comb = 2'd1;
      cmpa_din = 8'd40; cmpa_wr = 1'b1;
      step(1'b1);
      run(300);
      tg = 0; tgb = 0; prev_a = int'(wave_a); prev_b = int'(wave_b);
      for (int i = 0; i < 240; i++) begin
         step(1'b1);
         if (int'(wave_a) != prev_a) tg++;
         if (int'(wave_b) != prev_b) tgb++;
         prev_a = int'(wave_a); prev_b = int'(wave_b);
      end
      chk(tg == 3, "R5", "toggles in three periods", tg, 3);
      chk(tgb == 0, "R6", "channel B changes in mode 1", tgb, 0);
      top_sel = 1'b0;
      run(600);
      tg = 0; prev_a = int'(wave_a);
      for (int i = 0; i < 510; i++) begin
         step(1'b1);
         if (int'(wave_a) != prev_a) tg++;
         prev_a = int'(wave_a);
      end
      chk(tg == 0, "R5", "toggles with full ceiling", tg, 0);
      coma = 2'd0; comb = 2'd0;
      tg = 0; prev_a = int'(wave_a); prev_b = int'(wave_b);
      for (int i = 0; i < 510; i++) begin
         step(1'b1);
         if (int'(wave_a) != prev_a || int'(wave_b) != prev_b) tg++;
         prev_a = int'(wave_a); prev_b = int'(wave_b);
      end
      chk(tg == 0, "R6", "changes in hold mode", tg, 0);

      // R7 / R9: clear strobes away from any set event
      cmpb_din = 8'd100; cmpb_wr = 1'b1;
      step(1'b1);
      run(600);
      wait_at(120, 0);
      ovf_clr = 1'b1; cmpa_clr = 1'b1; cmpb_clr = 1'b1;
      step(1'b1);
      chk(ovf_flag == 1'b0, "R7", "overflow flag after clear", int'(ovf_flag), 0);
      chk(cmpa_flag == 1'b0, "R9", "A flag after clear", int'(cmpa_flag), 0);
      chk(cmpb_flag == 1'b0, "R9", "B flag after clear", int'(cmpb_flag), 0);
      wait_at(1, 0);
      chk(ovf_flag == 1'b1, "R7", "overflow flag at bottom", int'(ovf_flag), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule